// File: doc/BRIEF.md
# Timer with Watchdog Mode

A countdown timer built from a prescaler stage and a period stage. Software programs both through a small register bus. In timer mode each expiry sets a pending flag that can raise an interrupt, and the timer either stops after one period or reloads itself and keeps going. One mode bit turns the same counter into a watchdog. In that mode interrupts and continuous reload are forced off. Software must then write a service byte before the period runs out, or the block asks for a system reset with a single-cycle pulse.

The bus has three word registers, each selected by `addr`: 0 is mode, 1 is count and 2 is status. Writes honour per-byte lane enables and take effect on the clock edge that samples them. A read returns its data on `rdata` one edge after `rd_en` is sampled. The count register holds the prescaler in bits 31:16 and the period count in bits 15:0. Each expiry takes (prescaler, with 0 read as 65536) times (period count) prescaled steps. After a start or a service write, the counter first needs one edge to load.

Top module: `dual_role_timer`

## Requirements
- R1: After reset the mode, count and status registers read 0, and `irq` and `wdt_reset` are low.
- R2: The count register reads back all 32 written bits. Only these mode bits are stored: 17:16 capture edge (01 rising, 10 falling, 11 toggle; stored only), 15 watchdog enable, 12 counter enable, 10 continuous, 8 interrupt enable. Other mode bits read 0. Each byte lane is written only when its `be` bit is set.
- R3: Suppose a mode write sets counter enable (bit 12) at edge E while the counter is stopped, with prescaler P (nonzero) and count N. In timer mode, status bit 0 then becomes 1 right after edge E+1+P*N and not earlier. A count of 0 acts as 1. In one-shot mode there is no further expiry. Writing 1 to status bit 0 clears it, and status bits 3:1 read 0.
- R4: A prescaler of 0 divides by 65536.
- R5: With continuous mode (bit 10) set, the counter reloads on expiry and expires again every P*N cycles.
- R6: `irq` is high exactly while status bit 0 and interrupt enable (bit 8) are both 1. Setting the enable while the flag is pending raises `irq` after that write's edge.
- R7: Clearing counter enable halts counting, so no expiry follows.
- R8: A mode write with bit 15 set stores interrupt enable and continuous as 0. While in watchdog mode an expiry leaves status bit 0 at 0 and `irq` low.
- R9: In watchdog mode, an expiry with no service write drives `wdt_reset` high for exactly one clock, at the same edge where timer mode would set the flag. The counter then stops.
- R10: While watchdog mode is on, a write with lane 3 enabled and byte value 0xA5 in bits 31:24 reloads the counter. The next expiry then comes P*N edges after that write's edge, and the mode register is left unchanged. Any other value in that lane has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 mode, 1 count, 2 status |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte lane enables for writes |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Timer interrupt |
| wdt_reset | output | 1 | One-cycle watchdog reset request |

## Verification
The main function is driven with several prescaler and count pairs: small nonzero values, a zero count, and a zero prescaler with a count of one. Each expiry is pinned to its exact edge by checking the cycle before and the cycle of it, which separates an off-by-one in either stage from the rule that 0 means 65536. Continuous and one-shot runs are told apart by clearing the flag and watching for a second expiry. In watchdog mode, a service write made part way through the period must move the reset pulse later by a known amount, while a write of a wrong byte value must leave the pulse time unchanged.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;

  localparam int B_EDGE = 16;
  localparam int B_WDT  = 15;
  localparam int B_EN   = 12;
  localparam int B_CONT = 10;
  localparam int B_IE   = 8;

  localparam logic [7:0] KICK = 8'hA5;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       wdt;
    logic       en;
    logic       cont;
    logic       ie;
  } mode_t;
endpackage

// File: rtl/drt_regs.sv
module drt_regs
  import drt_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [1:0]             addr,
  input  logic [PRE_W+PER_W-1:0] wdata,
  input  logic [(PRE_W+PER_W)/8-1:0] be,
  input  logic                   expire,
  output mode_t                  mode,
  output logic [PRE_W-1:0]       pre_val,
  output logic [PER_W-1:0]       per_val,
  output logic                   kick,
  output logic                   flag,
  output logic [PRE_W+PER_W-1:0] rdata
);
  localparam int DW = PRE_W + PER_W;
  localparam int NB = DW / 8;

  logic [DW-1:0] count_q;
  logic [DW-1:0] mode_w, mode_nw, count_nw;
  mode_t         mode_n;
  logic          wr_mode, wr_count, wr_stat;

  function automatic logic [DW-1:0] pack_mode(mode_t m);
    logic [DW-1:0] w;
    w = '0;
    w[B_EDGE+1:B_EDGE] = m.edge_sel;
    w[B_WDT]  = m.wdt;
    w[B_EN]   = m.en;
    w[B_CONT] = m.cont;
    w[B_IE]   = m.ie;
    return w;
  endfunction

  assign wr_mode  = wr_en && (addr == A_MODE);
  assign wr_count = wr_en && (addr == A_COUNT);
  assign wr_stat  = wr_en && (addr == A_STAT);
  assign kick     = wr_mode && be[NB-1] && (wdata[DW-1 -: 8] == KICK) && mode.wdt;
  assign mode_w   = pack_mode(mode);

  always_comb begin
    mode_nw  = mode_w;
    count_nw = count_q;
    for (int b = 0; b < NB; b++) begin
      if (be[b]) begin
        mode_nw[b*8 +: 8]  = wdata[b*8 +: 8];
        count_nw[b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
    mode_n.edge_sel = mode_nw[B_EDGE+1:B_EDGE];
    mode_n.wdt      = mode_nw[B_WDT];
    mode_n.en       = mode_nw[B_EN];
    mode_n.cont     = mode_nw[B_CONT] && !mode_nw[B_WDT];
    mode_n.ie       = mode_nw[B_IE] && !mode_nw[B_WDT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      count_q <= '0;
      flag    <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr_mode && !kick) mode <= mode_n;
      if (wr_count) count_q <= count_nw;
      if (expire && !mode.wdt) flag <= 1'b1;
      else if (wr_stat && be[0] && wdata[0]) flag <= 1'b0;
      if (rd_en) begin
        case (addr)
          A_MODE:  rdata <= mode_w;
          A_COUNT: rdata <= count_q;
          A_STAT:  rdata <= {{(DW-1){1'b0}}, flag};
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign pre_val = count_q[DW-1 -: PRE_W];
  assign per_val = count_q[PER_W-1:0];
endmodule

// File: rtl/drt_counter.sv
module drt_counter #(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cont,
  input  logic             kick,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [PER_W-1:0] per_val,
  output logic             expire,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [PER_W-1:0] per_cnt
);
  logic             run_q, done, tick, last, start;
  logic [PRE_W-1:0] pre_top;

  assign pre_top = pre_val - 1'b1;
  assign start   = run && !run_q;
  assign tick    = run && run_q && !done && (pre_cnt == '0);
  assign last    = (per_cnt <= 1);
  assign expire  = tick && last && !kick;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      done    <= 1'b0;
      pre_cnt <= '0;
      per_cnt <= '0;
    end else begin
      run_q <= run;
      if (kick || start) begin
        pre_cnt <= pre_top;
        per_cnt <= per_val;
        done    <= 1'b0;
      end else if (run && run_q && !done) begin
        if (pre_cnt == '0) begin
          pre_cnt <= pre_top;
          if (last) begin
            if (cont) per_cnt <= per_val;
            else done <= 1'b1;
          end else begin
            per_cnt <= per_cnt - 1'b1;
          end
        end else begin
          pre_cnt <= pre_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_role_timer.sv
module dual_role_timer
  import drt_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        wdt_reset
);
  mode_t            mode;
  logic [PRE_W-1:0] pre_val, pre_cnt;
  logic [PER_W-1:0] per_val, per_cnt;
  logic             kick, flag, expire;

  drt_regs #(.PRE_W(PRE_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .be(be), .expire(expire), .mode(mode),
    .pre_val(pre_val), .per_val(per_val), .kick(kick), .flag(flag),
    .rdata(rdata)
  );

  drt_counter #(.PRE_W(PRE_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst(rst), .run(mode.en), .cont(mode.cont), .kick(kick),
    .pre_val(pre_val), .per_val(per_val), .expire(expire),
    .pre_cnt(pre_cnt), .per_cnt(per_cnt)
  );

  assign irq = flag && mode.ie;

  always_ff @(posedge clk) begin
    if (rst) wdt_reset <= 1'b0;
    else     wdt_reset <= expire && mode.wdt;
  end
endmodule

// File: rtl/drt_checker.sv
module drt_checker
  import drt_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             wdt_reset,
  input mode_t            mode,
  input logic             kick,
  input logic             expire,
  input logic [PRE_W-1:0] pre_val,
  input logic [PER_W-1:0] per_val,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PER_W-1:0] per_cnt
);
  logic [PRE_W-1:0] pre_top;
  assign pre_top = pre_val - 1'b1;

  p_wdt_single_r9: assert property (@(posedge clk) disable iff (rst)
    wdt_reset |=> !wdt_reset);

  p_wdt_mode_r9: assert property (@(posedge clk) disable iff (rst)
    wdt_reset |-> $past(mode.wdt));

  p_no_irq_wdt_r8: assert property (@(posedge clk) disable iff (rst)
    mode.wdt |-> !irq);

  p_forced_bits_r8: assert property (@(posedge clk) disable iff (rst)
    mode.wdt |-> (!mode.ie && !mode.cont));

  p_kick_reload_r10: assert property (@(posedge clk) disable iff (rst)
    kick |=> (pre_cnt == $past(pre_top)) && (per_cnt == $past(per_val)));

  p_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode.en && !kick) |=> ($stable(pre_cnt) && $stable(per_cnt)));

  p_oneshot_r3: assert property (@(posedge clk) disable iff (rst)
    (expire && !mode.cont && !kick) |=> !expire);
endmodule

bind dual_role_timer drt_checker #(.PRE_W(PRE_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .wdt_reset(wdt_reset), .mode(mode),
  .kick(kick), .expire(expire), .pre_val(pre_val), .per_val(per_val),
  .pre_cnt(pre_cnt), .per_cnt(per_cnt)
);

// File: tb/dual_role_timer_test.sv
`timescale 1ns/1ps
module dual_role_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic        irq, wdt_reset;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int pulses = 0;
  int w;
  int k;
  int p0;
  logic [31:0] rv;

  dual_role_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .be(be), .rdata(rdata), .irq(irq), .wdt_reset(wdt_reset)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (wdt_reset) pulses <= pulses + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; be = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; be = '0;
    w = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic idle();
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'h1, 4'hF);
  endtask

  task automatic t_reset();
    rd(2'd0, rv); chk("R1 mode", rv, 32'h0);
    rd(2'd1, rv); chk("R1 count", rv, 32'h0);
    rd(2'd2, rv); chk("R1 status", rv, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 wdt_reset", {31'b0, wdt_reset}, 32'h0);
  endtask

  task automatic t_regs();
    wr(2'd1, 32'h1234_ABCD, 4'hF);
    rd(2'd1, rv); chk("R2 count readback", rv, 32'h1234_ABCD);
    wr(2'd1, 32'h0000_5500, 4'b0010);
    rd(2'd1, rv); chk("R2 count lane", rv, 32'h1234_55CD);
    wr(2'd0, 32'h00FF_65FF, 4'hF);
    rd(2'd0, rv); chk("R2 mode bits", rv, 32'h0003_0500);
    wr(2'd0, 32'h0000_0000, 4'b0100);
    rd(2'd0, rv); chk("R2 mode lane", rv, 32'h0000_0500);
    idle();
  endtask

  task automatic t_oneshot();
    wr(2'd1, 32'h0003_0002, 4'hF);
    wr(2'd0, 32'h0000_1100, 4'hF);
    wait_to(w + 6); chk("R3 before expiry", {31'b0, irq}, 32'h0);
    wait_to(w + 7); chk("R3 at expiry", {31'b0, irq}, 32'h1);
    rd(2'd2, rv); chk("R3 status bit0", rv, 32'h1);
    wr(2'd2, 32'h1, 4'h1);
    rd(2'd2, rv); chk("R3 write-1 clear", rv, 32'h0);
    repeat (30) @(negedge clk);
    rd(2'd2, rv); chk("R3 one-shot no repeat", rv, 32'h0);
    idle();
    wr(2'd1, 32'h0005_0000, 4'hF);
    wr(2'd0, 32'h0000_1100, 4'hF);
    wait_to(w + 5); chk("R3 zero count before", {31'b0, irq}, 32'h0);
    wait_to(w + 6); chk("R3 zero count as one", {31'b0, irq}, 32'h1);
    idle();
  endtask

  task automatic t_pre0();
    wr(2'd1, 32'h0000_0001, 4'hF);
    wr(2'd0, 32'h0000_1100, 4'hF);
    wait_to(w + 65536); chk("R4 before 65536", {31'b0, irq}, 32'h0);
    wait_to(w + 65537); chk("R4 prescale 0 is 65536", {31'b0, irq}, 32'h1);
    idle();
  endtask

  task automatic t_cont();
    wr(2'd1, 32'h0004_0002, 4'hF);
    wr(2'd0, 32'h0000_1500, 4'hF);
    p0 = w;
    wait_to(p0 + 9); chk("R5 first expiry", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h1, 4'h1);
    chk("R5 cleared", {31'b0, irq}, 32'h0);
    wait_to(p0 + 16); chk("R5 before second", {31'b0, irq}, 32'h0);
    wait_to(p0 + 17); chk("R5 second expiry", {31'b0, irq}, 32'h1);
    idle();
  endtask

  task automatic t_mask();
    wr(2'd1, 32'h0002_0002, 4'hF);
    wr(2'd0, 32'h0000_1000, 4'hF);
    wait_to(w + 5); chk("R6 masked irq", {31'b0, irq}, 32'h0);
    rd(2'd2, rv); chk("R6 flag pending", rv, 32'h1);
    wr(2'd0, 32'h0000_1100, 4'hF);
    chk("R6 enable raises irq", {31'b0, irq}, 32'h1);
    idle();
  endtask

  task automatic t_halt();
    wr(2'd1, 32'h0004_0004, 4'hF);
    wr(2'd0, 32'h0000_1100, 4'hF);
    p0 = w;
    wait_to(p0 + 8);
    wr(2'd0, 32'h0000_0100, 4'hF);
    wait_to(p0 + 40);
    chk("R7 halted irq", {31'b0, irq}, 32'h0);
    rd(2'd2, rv); chk("R7 halted status", rv, 32'h0);
    idle();
  endtask

  task automatic t_wdt();
    wr(2'd1, 32'h0002_0003, 4'hF);
    wr(2'd0, 32'h0000_9500, 4'hF);
    p0 = w;
    rd(2'd0, rv); chk("R8 forced mode bits", rv, 32'h0000_9000);
    wait_to(p0 + 6); chk("R9 no early reset", {31'b0, wdt_reset}, 32'h0);
    wait_to(p0 + 7); chk("R9 reset pulse", {31'b0, wdt_reset}, 32'h1);
    wait_to(p0 + 8); chk("R9 single cycle", {31'b0, wdt_reset}, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    rd(2'd2, rv); chk("R8 status untouched", rv, 32'h0);
    k = pulses;
    repeat (40) @(negedge clk);
    chk("R9 stops after firing", pulses, k);
    idle();
  endtask

  task automatic t_service();
    wr(2'd1, 32'h0004_0004, 4'hF);
    wr(2'd0, 32'h0000_9000, 4'hF);
    p0 = w;
    wait_to(p0 + 10);
    k = pulses;
    wr(2'd0, 32'hA500_0000, 4'b1000);
    p0 = w;
    rd(2'd0, rv); chk("R10 mode unchanged by service", rv, 32'h0000_9000);
    wait_to(p0 + 15); chk("R10 old expiry suppressed", pulses, k);
    wait_to(p0 + 16); chk("R10 reloaded expiry", {31'b0, wdt_reset}, 32'h1);
    idle();
    wr(2'd0, 32'h0000_9000, 4'hF);
    p0 = w;
    wait_to(p0 + 5);
    wr(2'd0, 32'h5A00_0000, 4'b1000);
    wait_to(p0 + 16); chk("R10 wrong byte no effect early", {31'b0, wdt_reset}, 32'h0);
    wait_to(p0 + 17); chk("R10 wrong byte keeps expiry", {31'b0, wdt_reset}, 32'h1);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_oneshot();
    t_pre0();
    t_cont();
    t_mask();
    t_halt();
    t_wdt();
    t_service();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule